// File: doc/BRIEF.md
# Delayed Read Transaction Controller

This block turns every read arriving from the requesting side of a bus bridge into a split transaction. When a read begins, the block records its address, command and parity. The byte enables are recorded later, on the first cycle in which the requester signals it is ready. The finished record goes into a small pool of slots, and the requester is told to retry. On the far side, the oldest recorded read is started only after every posted write that was already waiting ahead of it has been delivered. The block keeps presenting that read until the target either moves at least one data word or ends it with an abort.

When the requester repeats a read whose address and command match a finished slot, the block answers with the stored data word and a completion status, then frees the slot. A repeat that matches a slot still in flight gets another retry. So does a new read that arrives while every slot is taken; neither is recorded. The data path and the number of words fetched are reduced to single-word handshakes, and the bus-level signal timing is abstracted the same way.

Top module: `dlyReadCtl`

## Requirements
- R1: After reset, `iRetry`, `iDone` and `tReq` are low and no slot is occupied.
- R2: `iAddr`, `iCmd` and `iPar` are recorded on the clock edge where `iStart` is high. `iBe` is recorded on the first later edge where `iRdy` is high, which commits the slot. `iRetry` is then high for exactly the one cycle after that edge.
- R3: With all DEPTH slots occupied, a new read with no matching slot gets `iRetry` in the cycle after `iStart`, and nothing is recorded: it is never issued on the far side.
- R4: `tReq` rises only for the oldest waiting slot, and only once every posted write that was outstanding when the slot was committed has been retired by a `pwDone` pulse. `pwQueued` counts a write in; writes counted in on or after the commit edge do not hold the slot back.
- R5: Slots are issued in the order they were committed. While `tReq` is high, `tAddr`, `tCmd` and `tPar` equal the recorded address, command and parity.
- R6: `tBe` is all zero (every lane enabled, active low) for a prefetchable read and equals the recorded byte enables otherwise. A read is prefetchable when its command is 4'hE (read line) or 4'hC (read multiple), or when it is 4'h6 (memory read) with an address inside the window [PF_BASE, PF_LIMIT]. I/O read (4'h2) and configuration read (4'hA) are never prefetchable.
- R7: `tCode` 2'd1 (retry) on a `tResp` edge leaves `tReq` high with the same address, command and byte enables. `tReq` falls in the cycle after a `tResp` edge that carries any other code.
- R8: `tCode` 2'd0 (data) completes the slot with `tData`. A repeat with equal address and command then gets `iDone` for one cycle, with that word on `iData` and `iStat` = 2'd0, and the slot is freed. A further repeat is treated as a new read.
- R9: `tCode` 2'd2 (master abort) or 2'd3 (target abort) completes the slot with that value as its status. The status is shown on `iStat` with `iDone` on the repeat.
- R10: A repeat that matches a slot not yet completed gets `iRetry`, and no `iDone`, in the next cycle, and no second copy of the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iStart | input | 1 | Address phase of a requester read |
| iAddr | input | AW | Requester read address |
| iCmd | input | 4 | Requester read command |
| iPar | input | 1 | Parity of the address phase |
| iRdy | input | 1 | Requester ready; its first assertion carries the byte enables |
| iBe | input | 4 | First-data-phase byte enables, active low |
| iRetry | output | 1 | One-cycle retry answer to the requester |
| iDone | output | 1 | One-cycle completion answer to a repeated read |
| iData | output | DW | Data word returned with iDone |
| iStat | output | 2 | Completion status: 0 ok, 2 master abort, 3 target abort |
| tReq | output | 1 | Far-side read in progress |
| tAddr | output | AW | Far-side read address |
| tCmd | output | 4 | Far-side read command |
| tPar | output | 1 | Recorded parity of the far-side read |
| tBe | output | 4 | Far-side byte enables, active low |
| tResp | input | 1 | Far-side response valid |
| tCode | input | 2 | Far-side response: 0 data, 1 retry, 2 master abort, 3 target abort |
| tData | input | DW | Far-side data word |
| pwQueued | input | 1 | One posted write enters the write queue |
| pwDone | input | 1 | One posted write has been delivered |

## Verification
The bench uses the default parameters: DEPTH = 4, AW = DW = 32, PWW = 4, and a prefetch window of 0x8000_0000 to 0x8FFF_FFFF. A depth of four lets four reads fill the pool while the first one is still held on the far side, so the full-pool refusal, the in-flight repeat and issue order can all be observed together. The window lets one memory read fall inside it and one outside, and puts an I/O read inside it, which separates the command rule from the address rule for byte enables. PWW = 4 is wide enough for the three-write scenario that shows a later write does not hold back an earlier read.

// File: rtl/drc_pkg.sv
package drc_pkg;

  // read command codes on both sides
  localparam logic [3:0] CMD_IORD  = 4'h2;
  localparam logic [3:0] CMD_MRD   = 4'h6;
  localparam logic [3:0] CMD_CFGRD = 4'hA;
  localparam logic [3:0] CMD_MRM   = 4'hC;
  localparam logic [3:0] CMD_MRL   = 4'hE;

  // far-side response codes; the non-retry ones double as completion status
  localparam logic [1:0] RSP_DATA   = 2'd0;
  localparam logic [1:0] RSP_RETRY  = 2'd1;
  localparam logic [1:0] RSP_MABORT = 2'd2;
  localparam logic [1:0] RSP_TABORT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // record address phase into holding registers
    logic commit;    // record byte enables, write slot, push issue order
    logic serve;     // return the matched finished slot and free it
    logic launch;    // load far-side registers from the oldest slot
    logic finish;    // far side ended; store status/data, pop order
  } drcStrobes_t;

endpackage

// File: rtl/drc_datapath.sv
module drc_datapath
  import drc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int PWW = 4,
  parameter logic [AW-1:0] PF_BASE  = 'h8000_0000,
  parameter logic [AW-1:0] PF_LIMIT = 'h8FFF_FFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  drcStrobes_t   strb,
  input  logic [AW-1:0] iAddr,
  input  logic [3:0]    iCmd,
  input  logic          iPar,
  input  logic [3:0]    iBe,
  input  logic [1:0]    tCode,
  input  logic [DW-1:0] tData,
  input  logic          pwQueued,
  input  logic          pwDone,
  output logic          hitDone,
  output logic          hitPend,
  output logic          qFull,
  output logic          headReady,
  output logic [DW-1:0] iData,
  output logic [1:0]    iStat,
  output logic [AW-1:0] tAddr,
  output logic [3:0]    tCmd,
  output logic          tPar,
  output logic [3:0]    tBe
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  // slot storage
  logic [DEPTH-1:0] slotValid, slotDone;
  logic [AW-1:0]    slotAddr  [DEPTH];
  logic [3:0]       slotCmd   [DEPTH];
  logic             slotPar   [DEPTH];
  logic [3:0]       slotBe    [DEPTH];
  logic [1:0]       slotStat  [DEPTH];
  logic [DW-1:0]    slotData  [DEPTH];
  logic [PWW-1:0]   slotAhead [DEPTH];

  // address phase holding registers
  logic [AW-1:0] holdAddr;
  logic [3:0]    holdCmd;
  logic          holdPar;

  // commit order
  logic [IW-1:0] ordQ [DEPTH];
  logic [IW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] ordCnt;

  logic [PWW-1:0] pwOut, aheadInit;
  logic [IW-1:0]  allocIdx, hitIdx, headIdx;
  logic           headPf;

  // lowest free slot
  always_comb begin
    allocIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!slotValid[i]) allocIdx = IW'(i);
  end
  assign qFull = &slotValid;

  // match incoming address phase against occupied slots
  always_comb begin
    hitDone = 1'b0;
    hitPend = 1'b0;
    hitIdx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slotValid[i] && slotAddr[i] == iAddr && slotCmd[i] == iCmd) begin
        hitIdx = IW'(i);
        if (slotDone[i]) hitDone = 1'b1;
        else             hitPend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdCmd  <= '0;
      holdPar  <= 1'b0;
    end else if (strb.capAddr) begin
      holdAddr <= iAddr;
      holdCmd  <= iCmd;
      holdPar  <= iPar;
    end
  end

  // outstanding posted writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwOut <= '0;
    else begin
      case ({pwQueued, pwDone})
        2'b10:   pwOut <= pwOut + 1'b1;
        2'b01:   pwOut <= (pwOut != '0) ? pwOut - 1'b1 : pwOut;
        default: pwOut <= pwOut;
      endcase
    end
  end

  // writes still ahead of a slot committed this cycle
  assign aheadInit = (pwDone && pwOut != '0) ? pwOut - 1'b1 : pwOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      slotDone  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slotAddr[i]  <= '0;
        slotCmd[i]   <= '0;
        slotPar[i]   <= 1'b0;
        slotBe[i]    <= '0;
        slotStat[i]  <= '0;
        slotData[i]  <= '0;
        slotAhead[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.commit && allocIdx == IW'(i)) begin
          slotValid[i] <= 1'b1;
          slotDone[i]  <= 1'b0;
          slotAddr[i]  <= holdAddr;
          slotCmd[i]   <= holdCmd;
          slotPar[i]   <= holdPar;
          slotBe[i]    <= iBe;
          slotAhead[i] <= aheadInit;
        end else begin
          if (pwDone && slotAhead[i] != '0)
            slotAhead[i] <= slotAhead[i] - 1'b1;
          if (strb.finish && headIdx == IW'(i)) begin
            slotDone[i] <= 1'b1;
            slotStat[i] <= tCode;
            slotData[i] <= tData;
          end
          if (strb.serve && hitIdx == IW'(i)) begin
            slotValid[i] <= 1'b0;
            slotDone[i]  <= 1'b0;
          end
        end
      end
    end
  end

  // commit order ring
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      ordCnt <= '0;
      for (int i = 0; i < DEPTH; i++) ordQ[i] <= '0;
    end else begin
      if (strb.commit) begin
        ordQ[wrPtr] <= allocIdx;
        wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      end
      if (strb.finish)
        rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({strb.commit, strb.finish})
        2'b10:   ordCnt <= ordCnt + 1'b1;
        2'b01:   ordCnt <= ordCnt - 1'b1;
        default: ordCnt <= ordCnt;
      endcase
    end
  end

  assign headIdx   = ordQ[rdPtr];
  assign headReady = (ordCnt != '0) && (slotAhead[headIdx] == '0);

  always_comb begin
    headPf = (slotCmd[headIdx] == CMD_MRL) || (slotCmd[headIdx] == CMD_MRM) ||
             (slotCmd[headIdx] == CMD_MRD && slotAddr[headIdx] >= PF_BASE &&
              slotAddr[headIdx] <= PF_LIMIT);
  end

  // far-side command registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tAddr <= '0;
      tCmd  <= '0;
      tPar  <= 1'b0;
      tBe   <= 4'hF;
    end else if (strb.launch) begin
      tAddr <= slotAddr[headIdx];
      tCmd  <= slotCmd[headIdx];
      tPar  <= slotPar[headIdx];
      tBe   <= headPf ? 4'h0 : slotBe[headIdx];
    end
  end

  // requester answer registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iData <= '0;
      iStat <= '0;
    end else if (strb.serve) begin
      iData <= slotData[hitIdx];
      iStat <= slotStat[hitIdx];
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !qFull);

  // R4
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |-> (ordCnt != '0 && slotAhead[headIdx] == '0));

  // R6
  pf_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && slotCmd[headIdx] == CMD_MRL) |=> (tBe == 4'h0));

  // R8
  serve_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.serve |-> (slotValid[hitIdx] && slotDone[hitIdx]));

endmodule

// File: rtl/drc_control.sv
module drc_control
  import drc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iStart,
  input  logic        iRdy,
  input  logic        tResp,
  input  logic [1:0]  tCode,
  input  logic        hitDone,
  input  logic        hitPend,
  input  logic        qFull,
  input  logic        headReady,
  output drcStrobes_t strb,
  output logic        iRetry,
  output logic        iDone,
  output logic        tReq
);

  typedef enum logic { I_IDLE, I_WAITBE } iState_t;
  typedef enum logic { T_IDLE, T_BUSY }   tState_t;

  iState_t iState;
  tState_t tState;
  logic    refuse;

  assign refuse = iState == I_IDLE && iStart && !hitDone && (hitPend || qFull);

  always_comb begin
    strb         = '0;
    strb.serve   = iState == I_IDLE && iStart && hitDone;
    strb.capAddr = iState == I_IDLE && iStart && !hitDone && !hitPend && !qFull;
    strb.commit  = iState == I_WAITBE && iRdy;
    strb.launch  = tState == T_IDLE && headReady;
    strb.finish  = tState == T_BUSY && tResp && tCode != RSP_RETRY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iState <= I_IDLE;
      iRetry <= 1'b0;
      iDone  <= 1'b0;
    end else begin
      iRetry <= refuse || strb.commit;
      iDone  <= strb.serve;
      if (strb.capAddr)     iState <= I_WAITBE;
      else if (strb.commit) iState <= I_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tState <= T_IDLE;
    else if (strb.launch) tState <= T_BUSY;
    else if (strb.finish) tState <= T_IDLE;
  end

  assign tReq = tState == T_BUSY;

  // R2
  commit_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (iRetry && !iDone));

  // R10
  pend_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iState == I_IDLE && iStart && hitPend) |=> (iRetry && !iDone));

  // R7
  hold_on_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tReq && tResp && tCode == RSP_RETRY) |=> tReq);

  // R7
  drop_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tReq && tResp && tCode != RSP_RETRY) |=> !tReq);

  // R8
  serve_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.serve |=> (iDone && !iRetry));

endmodule

// File: rtl/dlyReadCtl.sv
module dlyReadCtl
  import drc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int PWW = 4,
  parameter logic [AW-1:0] PF_BASE  = 'h8000_0000,
  parameter logic [AW-1:0] PF_LIMIT = 'h8FFF_FFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          iStart,
  input  logic [AW-1:0] iAddr,
  input  logic [3:0]    iCmd,
  input  logic          iPar,
  input  logic          iRdy,
  input  logic [3:0]    iBe,
  output logic          iRetry,
  output logic          iDone,
  output logic [DW-1:0] iData,
  output logic [1:0]    iStat,
  output logic          tReq,
  output logic [AW-1:0] tAddr,
  output logic [3:0]    tCmd,
  output logic          tPar,
  output logic [3:0]    tBe,
  input  logic          tResp,
  input  logic [1:0]    tCode,
  input  logic [DW-1:0] tData,
  input  logic          pwQueued,
  input  logic          pwDone
);

  drcStrobes_t strb;
  logic hitDone, hitPend, qFull, headReady;

  drc_control u_ctl (
    .clk(clk), .rstN(rstN), .iStart(iStart), .iRdy(iRdy),
    .tResp(tResp), .tCode(tCode), .hitDone(hitDone), .hitPend(hitPend),
    .qFull(qFull), .headReady(headReady), .strb(strb),
    .iRetry(iRetry), .iDone(iDone), .tReq(tReq)
  );

  drc_datapath #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .PWW(PWW),
    .PF_BASE(PF_BASE), .PF_LIMIT(PF_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .iAddr(iAddr), .iCmd(iCmd), .iPar(iPar), .iBe(iBe),
    .tCode(tCode), .tData(tData), .pwQueued(pwQueued), .pwDone(pwDone),
    .hitDone(hitDone), .hitPend(hitPend), .qFull(qFull), .headReady(headReady),
    .iData(iData), .iStat(iStat),
    .tAddr(tAddr), .tCmd(tCmd), .tPar(tPar), .tBe(tBe)
  );

  // R5
  stable_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tReq && $past(tReq)) |-> ($stable(tAddr) && $stable(tCmd) && $stable(tBe)));

endmodule

// File: tb/sim_dlyReadCtl.sv
`timescale 1ns/1ps
module sim_dlyReadCtl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iStart = 1'b0, iPar = 1'b0, iRdy = 1'b0;
  logic [31:0] iAddr = '0;
  logic [3:0]  iCmd = '0, iBe = 4'hF;
  logic        iRetry, iDone, tReq, tPar;
  logic [31:0] iData, tAddr;
  logic [1:0]  iStat;
  logic [3:0]  tCmd, tBe;
  logic        tResp = 1'b0, pwQueued = 1'b0, pwDone = 1'b0;
  logic [1:0]  tCode = '0;
  logic [31:0] tData = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  dlyReadCtl u0 (
    .clk(clk), .rstN(rstN), .iStart(iStart), .iAddr(iAddr), .iCmd(iCmd),
    .iPar(iPar), .iRdy(iRdy), .iBe(iBe), .iRetry(iRetry), .iDone(iDone),
    .iData(iData), .iStat(iStat), .tReq(tReq), .tAddr(tAddr), .tCmd(tCmd),
    .tPar(tPar), .tBe(tBe), .tResp(tResp), .tCode(tCode), .tData(tData),
    .pwQueued(pwQueued), .pwDone(pwDone)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // new read: address phase, optional wait, then ready with byte enables
  task automatic newReq(input logic [31:0] a, input logic [3:0] c,
                        input logic [3:0] be, input int waitCyc);
    iStart = 1; iAddr = a; iCmd = c; iPar = ^{a, c};
    step();
    iStart = 0; iAddr = 32'hDEAD_0000; iCmd = 4'h0; iPar = 0;
    iBe = 4'hF;
    for (int k = 0; k < waitCyc; k++) begin
      chk(iRetry == 0, "R2 no retry before ready", iRetry, 0);
      step();
    end
    iRdy = 1; iBe = be;
    step();
    iRdy = 0; iBe = 4'hF;
    chk(iRetry == 1 && iDone == 0, "R2 retry after ready", iRetry, 1);
  endtask

  // repeated read: one address phase, look at the answer next cycle
  task automatic repeatReq(input logic [31:0] a, input logic [3:0] c,
                           input bit expDone, input logic [31:0] expData,
                           input logic [1:0] expStat, input string req);
    iStart = 1; iAddr = a; iCmd = c; iPar = ^{a, c};
    step();
    iStart = 0; iAddr = 32'hDEAD_0000; iCmd = 4'h0;
    chk(iDone == expDone && iRetry == !expDone, req, {iDone, iRetry},
        {expDone, !expDone});
    if (expDone) begin
      chk(iData == expData, req, iData, expData);
      chk(iStat == expStat, req, iStat, expStat);
    end
  endtask

  // far side: wait for the request, answer with retries then a final code
  task automatic targetServe(input logic [31:0] a, input logic [3:0] c,
                             input logic [3:0] be, input int nRetry,
                             input logic [1:0] code, input logic [31:0] d,
                             input string req);
    int guard = 0;
    while (!tReq && guard < 50) begin step(); guard++; end
    chk(tReq == 1, "R5 request appears", tReq, 1);
    chk(tAddr == a && tCmd == c, req, tAddr, a);
    chk(tPar == ^{a, c}, "R5 parity carried", tPar, ^{a, c});
    chk(tBe == be, "R6 byte enables", tBe, be);
    for (int k = 0; k < nRetry; k++) begin
      tResp = 1; tCode = 2'd1;
      step();
      tResp = 0;
      chk(tReq == 1 && tAddr == a && tBe == be, "R7 held after retry", tAddr, a);
    end
    tResp = 1; tCode = code; tData = d;
    step();
    tResp = 0; tCode = 0; tData = 0;
    chk(tReq == 0, "R7 released after final response", tReq, 0);
  endtask

  task automatic test_reset();
    chk(iRetry == 0 && iDone == 0 && tReq == 0, "R1 reset outputs",
        {iRetry, iDone, tReq}, 0);
  endtask

  task automatic test_write_gate();
    pwQueued = 1; step(); step(); pwQueued = 0;   // two writes ahead
    newReq(32'h0000_0100, 4'h6, 4'b0011, 2);
    pwQueued = 1; step(); pwQueued = 0;           // newer write
    for (int k = 0; k < 3; k++) begin
      chk(tReq == 0, "R4 blocked by older writes", tReq, 0);
      step();
    end
    pwDone = 1; step(); pwDone = 0;
    step();
    chk(tReq == 0, "R4 one older write left", tReq, 0);
    pwDone = 1; step(); pwDone = 0;
    chk(tReq == 0, "R4 launch one cycle later", tReq, 0);
    step();
    chk(tReq == 1, "R4 launch after older writes drained", tReq, 1);
    targetServe(32'h0000_0100, 4'h6, 4'b0011, 0, 2'd0, 32'h1111_2222,
                "R2 recorded address and command");
    repeatReq(32'h0000_0100, 4'h6, 1, 32'h1111_2222, 2'd0, "R8 serve ok");
    pwDone = 1; step(); pwDone = 0;
  endtask

  task automatic test_full_order();
    newReq(32'h0000_0200, 4'h6, 4'b1010, 0);  // A non-prefetchable
    newReq(32'h8000_0040, 4'h6, 4'b0101, 0);  // B memory read in window
    newReq(32'h0000_0300, 4'hE, 4'b0110, 1);  // C read line
    newReq(32'h8000_0080, 4'h2, 4'b1100, 0);  // D I/O read in window
    repeatReq(32'h0000_0400, 4'h6, 0, 0, 0, "R3 full pool refuses");
    repeatReq(32'h8000_0040, 4'h6, 0, 0, 0, "R10 repeat of pending slot");
    targetServe(32'h0000_0200, 4'h6, 4'b1010, 2, 2'd0, 32'hAAAA_0001, "R5 order A");
    targetServe(32'h8000_0040, 4'h6, 4'b0000, 0, 2'd2, 32'h0, "R5 order B");
    targetServe(32'h0000_0300, 4'hE, 4'b0000, 1, 2'd3, 32'h0, "R5 order C");
    targetServe(32'h8000_0080, 4'h2, 4'b1100, 0, 2'd0, 32'hDDDD_0004, "R5 order D");
    for (int k = 0; k < 5; k++) begin
      chk(tReq == 0, "R3 R10 nothing extra issued", tReq, 0);
      step();
    end
    repeatReq(32'h0000_0200, 4'h6, 1, 32'hAAAA_0001, 2'd0, "R8 serve A");
    repeatReq(32'h8000_0040, 4'h6, 1, 32'h0, 2'd2, "R9 master abort status");
    repeatReq(32'h0000_0300, 4'hE, 1, 32'h0, 2'd3, "R9 target abort status");
    repeatReq(32'h8000_0080, 4'h2, 1, 32'hDDDD_0004, 2'd0, "R8 serve D");
    // slot of A was freed: a further repeat starts a fresh read
    newReq(32'h0000_0200, 4'h6, 4'b0111, 0);
    targetServe(32'h0000_0200, 4'h6, 4'b0111, 0, 2'd0, 32'h5555_6666,
                "R8 freed slot reissued");
    repeatReq(32'h0000_0200, 4'h6, 1, 32'h5555_6666, 2'd0, "R8 second serve");
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    test_reset();
    test_write_gate();
    test_full_order();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule